// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the per-channel control and status state for a four-channel DMA engine. Each channel owns one byte-wide register. The register holds an end-of-transfer flag that clears when software reads it, a mode bit that keeps the channel enabled once its transfer count is exhausted, a one-shot forced-termination command, a one-shot software-start command and an enable bit. Software reaches the registers over a simple byte bus with address, write strobe, read strobe and write data. Read data is combinational from the address.

The transfer engine reports terminal count per channel. Peripherals raise per-channel hardware requests. A non-maskable interrupt input stops every channel at once. The block decides which requests it accepts, and it tells the engine through one-cycle start and abort pulses and a level enable per channel. Address generation and the data path are not part of this block. A channel counts as busy from an accepted start until its terminal count, a forced termination or the interrupt.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register reads 0x00, and start_o, abort_o and enable_o are all 0.
- R2: Channel k's register is at byte address 2k (k = 0..3). Odd addresses read 0x00 and ignore writes. The byte reads back as bit 7 end flag, bit 3 retain mode, bit 0 enable. All other bits, including the start command (bit 1) and the termination command (bit 2), read as 0.
- R3: The end flag cannot be written. It becomes 1 in the cycle after tc_in[k]. A read of the register clears it. When terminal count and a read of the same register fall in the same cycle, the flag is 1 afterwards.
- R4: At terminal count with retain mode 1, the enable bit stays 1.
- R5: At terminal count with retain mode 0, the enable bit is cleared.
- R6: A hardware request hw_req[k] is accepted when the enable bit is 1 and either the end flag is 0 or retain mode is 1. Otherwise it is ignored and no start pulse appears.
- R7: Writing the register with bit 1 = 1 and bit 0 = 1 starts the channel only when the enable bit was already 1 and the end flag is 0.
- R8: Writing the register with bit 2 = 1 clears the enable bit. It raises abort_o[k] for one cycle only if the channel was busy.
- R9: A cycle with nmi_in high clears every enable bit and raises abort_o for one cycle on each channel that was busy.
- R10: Each accepted request gives a start_o[k] pulse of one cycle in the cycle after acceptance. enable_o[k] follows the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address within the block |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the end flag of the addressed channel) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| hw_req | input | 4 | Per-channel peripheral request |
| tc_in | input | 4 | Per-channel terminal count from the engine |
| nmi_in | input | 1 | Non-maskable stop of all channels |
| start_o | output | 4 | One-cycle start pulse per channel |
| abort_o | output | 4 | One-cycle abort pulse per channel |
| enable_o | output | 4 | Enable bit per channel |

## Verification
Terminal count and a software read of the same channel register can fall in the same cycle. One sets the end flag and the other clears it. The bench raises tc_in[3] in the same cycle as a read strobe at address 6. Two later reads must return the flag as 1 and then 0. Further scenarios present requests against a flag that has not been read, in both retain modes, so the blocking and passing cases of each start source are checked.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int BIT_EN   = 0;
  localparam int BIT_STG  = 1;
  localparam int BIT_KILL = 2;
  localparam int BIT_MODE = 3;
  localparam int BIT_FLAG = 7;

  typedef struct packed {
    logic flag;
    logic mode;
    logic en;
  } chan_state_t;

  function automatic logic [7:0] pack_status(chan_state_t s);
    logic [7:0] b;
    b           = 8'h00;
    b[BIT_FLAG] = s.flag;
    b[BIT_MODE] = s.mode;
    b[BIT_EN]   = s.en;
    return b;
  endfunction
endpackage

// File: rtl/dma_cc_decode.sv
module dma_cc_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NUM_CH-1:0] sel,
  output logic [NUM_CH-1:0] wr_hit,
  output logic [NUM_CH-1:0] rd_hit
);
  localparam int IDX_W = ADDR_W - 1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    // even offsets only; odd addresses select nothing (R2)
    assign sel[i]    = (addr[0] == 1'b0) && (addr[ADDR_W-1:1] == IDX_W'(i));
    assign wr_hit[i] = sel[i] & wr;
    assign rd_hit[i] = sel[i] & rd;
  end
endmodule

// File: rtl/dma_cc_rdmux.sv
module dma_cc_rdmux #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic [NUM_CH-1:0]             sel,
  input  logic [NUM_CH-1:0][DATA_W-1:0] status,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      rdata = rdata | ({DATA_W{sel[i]}} & status[i]);
    end
  end
endmodule

// File: rtl/dma_cc_chan.sv
module dma_cc_chan
  import dma_cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       rd_hit,
  input  logic [3:0] wbits,
  input  logic       hw_req,
  input  logic       tc_in,
  input  logic       nmi,
  output logic [7:0] status,
  output logic       start_o,
  output logic       abort_o,
  output logic       en_o
);
  logic flag_q, flag_d;
  logic mode_q, mode_d;
  logic en_q, en_d;
  logic busy_q, busy_d;
  logic start_q, abort_q;
  logic stg_wr, kill, sw_ok, hw_ok, accept;

  assign stg_wr = wr_hit & wbits[BIT_STG];
  assign kill   = nmi | (wr_hit & wbits[BIT_KILL]);
  assign sw_ok  = stg_wr & en_q & wbits[BIT_EN] & ~flag_q & ~kill;
  assign hw_ok  = hw_req & en_q & (~flag_q | mode_q) & ~kill;
  assign accept = sw_ok | hw_ok;

  always_comb begin
    mode_d = wr_hit ? wbits[BIT_MODE] : mode_q;
    en_d   = wr_hit ? wbits[BIT_EN]   : en_q;
    if (tc_in && !mode_q) en_d = 1'b0;
    if (kill)             en_d = 1'b0;

    flag_d = flag_q;
    if (rd_hit) flag_d = 1'b0;
    if (tc_in)  flag_d = 1'b1;

    busy_d = busy_q;
    if (tc_in)  busy_d = 1'b0;
    if (accept) busy_d = 1'b1;
    if (kill)   busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
      busy_q  <= busy_d;
      start_q <= accept;
      abort_q <= kill & busy_q;
    end
  end

  chan_state_t st;
  assign st      = '{flag: flag_q, mode: mode_q, en: en_q};
  assign status  = pack_status(st);
  assign start_o = start_q;
  assign abort_o = abort_q;
  assign en_o    = en_q;

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_in |=> flag_q);
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && !tc_in |=> !flag_q);
  p_keep_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_in && mode_q && en_q && !kill && !wr_hit |=> en_q);
  p_drop_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_in && !mode_q |=> !en_q);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_q);
  p_sw_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stg_wr && flag_q && !hw_req |=> !start_o);
  p_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && wbits[BIT_KILL] |=> !en_q && !busy_q);
  p_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !en_q && !start_o);
  p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] tc_in,
  input  logic              nmi_in,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] abort_o,
  output logic [NUM_CH-1:0] enable_o
);
  localparam int CMD_W = 4;

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [NUM_CH-1:0]             sel, wr_hit, rd_hit;
  logic [NUM_CH-1:0][DATA_W-1:0] status;
  logic                          unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CMD_W];

  dma_cc_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .sel(sel), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_cc_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_s2_q),
      .wr_hit (wr_hit[i]),
      .rd_hit (rd_hit[i]),
      .wbits  (bus_wdata[CMD_W-1:0]),
      .hw_req (hw_req[i]),
      .tc_in  (tc_in[i]),
      .nmi    (nmi_in),
      .status (status[i]),
      .start_o(start_o[i]),
      .abort_o(abort_o[i]),
      .en_o   (enable_o[i])
    );
  end

  dma_cc_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .sel(sel), .status(status), .rdata(bus_rdata)
  );
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd, nmi_in;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] hw_req, tc_in, start_o, abort_o, enable_o;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_chan_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic hw(input int k);
    @(negedge clk); hw_req[k] = 1'b1;
    @(negedge clk); hw_req = '0;
  endtask

  task automatic tc(input int k);
    @(negedge clk); tc_in[k] = 1'b1;
    @(negedge clk); tc_in = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(3'(2*k), v); chk("R1 reg", v, 8'h00);
    end
    chk("R1 outs", {start_o, abort_o}, 8'h00);
    chk("R1 en", {4'h0, enable_o}, 8'h00);
  endtask

  task automatic t_layout;
    logic [7:0] v;
    wr(3'd4, 8'hFB);
    chk("R2 no start", {4'h0, start_o}, 8'h00);
    rd(3'd4, v); chk("R2 readback", v, 8'h09);
    chk("R10 enable_o", {4'h0, enable_o}, 8'h04);
    wr(3'd5, 8'h00);
    rd(3'd4, v); chk("R2 odd write ignored", v, 8'h09);
    rd(3'd5, v); chk("R2 odd read", v, 8'h00);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R2 cleared", v, 8'h00);
  endtask

  task automatic t_sw_start;
    logic [7:0] v;
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h03);
    chk("R7 sw start", {4'h0, start_o}, 8'h01);
    @(negedge clk); chk("R10 pulse width", {4'h0, start_o}, 8'h00);
    tc(0);
    chk("R5 en dropped", {7'h0, enable_o[0]}, 8'h00);
    rd(3'd0, v); chk("R3 flag set", v, 8'h80);
    rd(3'd0, v); chk("R3 flag read-clear", v, 8'h00);
  endtask

  task automatic t_mode_retain;
    logic [7:0] v;
    wr(3'd2, 8'h09);
    hw(1); chk("R6 hw start", {4'h0, start_o}, 8'h02);
    tc(1); chk("R4 en kept", {7'h0, enable_o[1]}, 8'h01);
    hw(1); chk("R6 hw with unread flag", {4'h0, start_o}, 8'h02);
    wr(3'd2, 8'h0B); chk("R7 sw blocked by flag", {4'h0, start_o}, 8'h00);
    rd(3'd2, v); chk("R3 status", v, 8'h89);
    wr(3'd2, 8'h0B); chk("R7 sw after read", {4'h0, start_o}, 8'h02);
  endtask

  task automatic t_mode_drop;
    logic [7:0] v;
    hw(0); chk("R6 disabled ignored", {4'h0, start_o}, 8'h00);
    wr(3'd0, 8'h01);
    tc(0); chk("R5 en cleared", {7'h0, enable_o[0]}, 8'h00);
    wr(3'd0, 8'h01);
    hw(0); chk("R6 blocked by flag mode0", {4'h0, start_o}, 8'h00);
    rd(3'd0, v); chk("R3 flag", v, 8'h81);
    hw(0); chk("R6 accepted after read", {4'h0, start_o}, 8'h01);
  endtask

  task automatic t_kill;
    logic [7:0] v;
    wr(3'd0, 8'h05);
    chk("R8 abort busy", {4'h0, abort_o}, 8'h01);
    chk("R8 en cleared", {7'h0, enable_o[0]}, 8'h00);
    rd(3'd0, v); chk("R2 cmd bits read 0", v, 8'h00);
    wr(3'd6, 8'h01);
    wr(3'd6, 8'h04);
    chk("R8 idle no abort", {4'h0, abort_o}, 8'h00);
    chk("R8 idle en cleared", {7'h0, enable_o[3]}, 8'h00);
  endtask

  task automatic t_nmi;
    logic [7:0] v;
    wr(3'd4, 8'h01);
    chk("R9 pre en", {4'h0, enable_o}, 8'h06);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    chk("R9 abort busy only", {4'h0, abort_o}, 8'h02);
    chk("R9 all disabled", {4'h0, enable_o}, 8'h00);
    rd(3'd2, v); chk("R9 mode kept", v, 8'h08);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    @(negedge clk); bus_addr = 3'd6; bus_rd = 1'b1; tc_in[3] = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tc_in = '0;
    rd(3'd6, v); chk("R3 set wins", v, 8'h80);
    rd(3'd6, v); chk("R3 cleared after", v, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; hw_req = '0; tc_in = '0; nmi_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_layout;
    t_sw_start;
    t_mode_retain;
    t_mode_drop;
    t_kill;
    t_nmi;
    t_collide;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule